// File: doc/BRIEF.md
# Four-Segment Floating-Point Adder Pipeline

This block adds or subtracts two numbers in a reduced floating-point format: one sign bit, an 8-bit biased exponent and a 16-bit mantissa whose leading one is stored. The work is divided into four registered segments. The first segment compares the exponents by subtraction. The second segment aligns the smaller operand. The third segment adds or subtracts the mantissas. The fourth segment normalizes the result and corrects the exponent to match.

A new operation may enter on every clock. Each result appears a fixed four clocks after its operands, together with its own valid flag, so up to four operations are in progress at once. The result is truncated and is not rounded. Denormals, infinities and NaNs are not handled. Exponent overflow and underflow are not detected.

Top module: `fp_add_pipe`

## Requirements
- R1: An operand or result word holds the sign in bit 24 (1 = negative), the biased exponent in bits 23:16 and the mantissa in bits 15:0, with the leading one in bit 15. Zero is encoded with exponent 0 and mantissa 0.
- R2: A result is presented, with `res_vld` high, exactly four clocks after the clock edge that accepts its operands with `opd_vld` high. Clock edges with `opd_vld` low produce a cycle with `res_vld` low four clocks later.
- R3: The operand with the larger exponent (operand a when the exponents are equal) provides the provisional exponent. The other mantissa is shifted right by the exponent difference, and the bits shifted out are discarded.
- R4: When the exponent difference is 16 or more, the smaller operand contributes nothing, and the result equals the larger operand (after the sign effect of R5).
- R5: When `op_sub` is 1 the block computes a − b by inverting the sign of b. When `op_sub` is 0 it computes a + b.
- R6: When the mantissa sum carries out of bit 15, the sum is shifted right by one, its lowest bit is dropped, and the exponent is increased by one.
- R7: When the mantissa result has k leading zeros below bit 15, it is shifted left by k, and the exponent is decreased by k.
- R8: When operands of opposite effective sign are combined and the aligned smaller-exponent magnitude is the larger one, the result magnitude is their positive difference, and the result takes that operand's sign.
- R9: A zero mantissa result is output as the all-zero word (positive sign, exponent 0).
- R10: Operations presented on consecutive clocks are processed independently, and each keeps its own result and order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| opd_vld | input | 1 | Operands and control are valid this cycle |
| opd_a | input | 25 | First operand {sign, exponent, mantissa} |
| opd_b | input | 25 | Second operand {sign, exponent, mantissa} |
| op_sub | input | 1 | 1 = subtract b from a, 0 = add |
| res_vld | output | 1 | Result is valid this cycle |
| res | output | 25 | Normalized, truncated result |

## Verification
The assertions assume that every nonzero operand has bit 15 of its mantissa set. They also assume that the result exponent stays within 1..255 after normalization, because the block does not guard against exponent wrap. The random stimulus draws nonzero exponents from 20 to 230 and always sets the mantissa's leading one. It also mixes in exact zeros, identical operands and directed cases near the 16-bit alignment limit.

// File: rtl/fpa_pkg.sv
// Shared widths and stage record types for the floating-point adder pipe.
// Assumes a stored leading one in the mantissa's top bit.
package fpa_pkg;
    localparam int EXP_W  = 8;
    localparam int MAN_W  = 16;
    localparam int WORD_W = 1 + EXP_W + MAN_W;
    localparam int LZ_W   = $clog2(MAN_W) + 1;

    typedef struct packed {
        logic             sign;
        logic [EXP_W-1:0] exp;
        logic [MAN_W-1:0] man;
    } fp_word_t;

    // After exponent compare
    typedef struct packed {
        logic             vld;
        logic [EXP_W-1:0] exp;
        logic             big_sign;
        logic [MAN_W-1:0] big_man;
        logic             sml_sign;
        logic [MAN_W-1:0] sml_man;
        logic [EXP_W-1:0] shamt;
    } cmp_rec_t;

    // After alignment
    typedef struct packed {
        logic             vld;
        logic [EXP_W-1:0] exp;
        logic             big_sign;
        logic [MAN_W-1:0] big_man;
        logic             sml_sign;
        logic [MAN_W-1:0] sml_man;
    } aln_rec_t;

    // After mantissa add/subtract
    typedef struct packed {
        logic             vld;
        logic [EXP_W-1:0] exp;
        logic             sign;
        logic [MAN_W:0]   sum;
    } sum_rec_t;
endpackage

// File: rtl/fpa_exp_cmp.sv
// Segment 1: subtracts the exponents, picks the larger exponent as the
// provisional result exponent, routes operands to big/small lanes, and
// applies the subtract control to b's sign. Assumes valid-qualified inputs.
module fpa_exp_cmp
    import fpa_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     vld_i,
    input  fp_word_t a_i,
    input  fp_word_t b_i,
    input  logic     sub_i,
    output cmp_rec_t rec_o
);
    logic [EXP_W:0] diff;
    logic           b_sign_eff;
    cmp_rec_t       nxt;

    // Compare exponents by subtraction and choose lanes
    always_comb begin
        diff       = {1'b0, a_i.exp} - {1'b0, b_i.exp};
        b_sign_eff = b_i.sign ^ sub_i;
        nxt.vld    = vld_i;
        if (!diff[EXP_W]) begin
            nxt.exp      = a_i.exp;
            nxt.big_sign = a_i.sign;
            nxt.big_man  = a_i.man;
            nxt.sml_sign = b_sign_eff;
            nxt.sml_man  = b_i.man;
            nxt.shamt    = diff[EXP_W-1:0];
        end else begin
            nxt.exp      = b_i.exp;
            nxt.big_sign = b_sign_eff;
            nxt.big_man  = b_i.man;
            nxt.sml_sign = a_i.sign;
            nxt.sml_man  = a_i.man;
            nxt.shamt    = b_i.exp - a_i.exp;
        end
    end

    // Segment 1 register
    always_ff @(posedge clk) begin
        if (!rst_n) rec_o <= '0;
        else        rec_o <= nxt;
    end

    AST_EXP_IS_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        vld_i |=> (rec_o.exp >= $past(a_i.exp)) && (rec_o.exp >= $past(b_i.exp))); // R3
endmodule

// File: rtl/fpa_align.sv
// Segment 2: shifts the smaller-exponent mantissa right by the exponent
// difference; a difference at or past the mantissa width flushes it to zero.
module fpa_align
    import fpa_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  cmp_rec_t rec_i,
    output aln_rec_t rec_o
);
    localparam logic [EXP_W-1:0] FLUSH_AT = EXP_W'(MAN_W);

    aln_rec_t nxt;

    // Right-align the smaller operand
    always_comb begin
        nxt.vld      = rec_i.vld;
        nxt.exp      = rec_i.exp;
        nxt.big_sign = rec_i.big_sign;
        nxt.big_man  = rec_i.big_man;
        nxt.sml_sign = rec_i.sml_sign;
        if (rec_i.shamt >= FLUSH_AT) nxt.sml_man = '0;
        else                         nxt.sml_man = rec_i.sml_man >> rec_i.shamt;
    end

    // Segment 2 register
    always_ff @(posedge clk) begin
        if (!rst_n) rec_o <= '0;
        else        rec_o <= nxt;
    end

    AST_ALIGN_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_i.vld && rec_i.shamt >= FLUSH_AT) |=> (rec_o.sml_man == '0)); // R4
    AST_ALIGN_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
        rec_i.vld |=> (rec_o.sml_man <= $past(rec_i.sml_man))); // R3
endmodule

// File: rtl/fpa_mant_add.sv
// Segment 3: adds mantissas of equal sign, or subtracts the smaller
// magnitude from the larger one and takes the sign of the larger.
module fpa_mant_add
    import fpa_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  aln_rec_t rec_i,
    output sum_rec_t rec_o
);
    sum_rec_t nxt;
    logic     opp;

    // Signed-magnitude add/subtract
    always_comb begin
        opp     = rec_i.big_sign ^ rec_i.sml_sign;
        nxt.vld = rec_i.vld;
        nxt.exp = rec_i.exp;
        if (!opp) begin
            nxt.sum  = {1'b0, rec_i.big_man} + {1'b0, rec_i.sml_man};
            nxt.sign = rec_i.big_sign;
        end else if (rec_i.big_man >= rec_i.sml_man) begin
            nxt.sum  = {1'b0, rec_i.big_man - rec_i.sml_man};
            nxt.sign = rec_i.big_sign;
        end else begin
            nxt.sum  = {1'b0, rec_i.sml_man - rec_i.big_man};
            nxt.sign = rec_i.sml_sign;
        end
    end

    // Segment 3 register
    always_ff @(posedge clk) begin
        if (!rst_n) rec_o <= '0;
        else        rec_o <= nxt;
    end

    AST_SUB_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_i.vld && (rec_i.big_sign != rec_i.sml_sign)) |=> !rec_o.sum[MAN_W]); // R8
endmodule

// File: rtl/fpa_normalize.sv
// Segment 4: normalizes the raw sum (right by one on carry, left by the
// leading-zero count otherwise), adjusts the exponent and forces zero to
// the all-zero word. Exponent wrap is not guarded.
module fpa_normalize
    import fpa_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  sum_rec_t rec_i,
    output logic     vld_o,
    output fp_word_t res_o
);
    // Leading zeros of a mantissa-width value (nonzero assumed)
    function automatic logic [LZ_W-1:0] lead_zeros(input logic [MAN_W-1:0] v);
        logic [LZ_W-1:0] n;
        logic            hit;
        n   = '0;
        hit = 1'b0;
        for (int i = MAN_W - 1; i >= 0; i--) begin
            if (v[i]) hit = 1'b1;
            else if (!hit) n = n + 1'b1;
        end
        return n;
    endfunction

    logic [LZ_W-1:0] lz;
    fp_word_t        nxt;

    // Normalize mantissa and adjust exponent
    always_comb begin
        lz  = lead_zeros(rec_i.sum[MAN_W-1:0]);
        nxt = '0;
        if (rec_i.sum[MAN_W]) begin
            nxt.sign = rec_i.sign;
            nxt.exp  = rec_i.exp + 1'b1;
            nxt.man  = rec_i.sum[MAN_W:1];
        end else if (rec_i.sum != '0) begin
            nxt.sign = rec_i.sign;
            nxt.exp  = rec_i.exp - EXP_W'(lz);
            nxt.man  = rec_i.sum[MAN_W-1:0] << lz;
        end
    end

    // Segment 4 register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_o <= 1'b0;
            res_o <= '0;
        end else begin
            vld_o <= rec_i.vld;
            res_o <= nxt;
        end
    end

    AST_CARRY_BUMP: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_i.vld && rec_i.sum[MAN_W]) |=> (res_o.exp == $past(rec_i.exp) + 1'b1)); // R6
    AST_LEAD_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_o && res_o.man != '0) |-> res_o.man[MAN_W-1]); // R7
    AST_ZERO_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_o && res_o.man == '0) |-> (res_o.exp == '0 && !res_o.sign)); // R9
endmodule

// File: rtl/fp_add_pipe.sv
// Top: four-segment floating-point add/subtract pipeline, one operation per
// clock, fixed four-clock latency, valid carried beside the data.
module fp_add_pipe
    import fpa_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              opd_vld,
    input  logic [WORD_W-1:0] opd_a,
    input  logic [WORD_W-1:0] opd_b,
    input  logic              op_sub,
    output logic              res_vld,
    output logic [WORD_W-1:0] res
);
    cmp_rec_t s1;
    aln_rec_t s2;
    sum_rec_t s3;
    fp_word_t res_w;

    fpa_exp_cmp u_seg1 (
        .clk(clk), .rst_n(rst_n), .vld_i(opd_vld),
        .a_i(fp_word_t'(opd_a)), .b_i(fp_word_t'(opd_b)), .sub_i(op_sub), .rec_o(s1)
    );
    fpa_align u_seg2 (.clk(clk), .rst_n(rst_n), .rec_i(s1), .rec_o(s2));
    fpa_mant_add u_seg3 (.clk(clk), .rst_n(rst_n), .rec_i(s2), .rec_o(s3));
    fpa_normalize u_seg4 (.clk(clk), .rst_n(rst_n), .rec_i(s3), .vld_o(res_vld), .res_o(res_w));

    assign res = res_w;

    AST_VLD_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
        opd_vld |=> s1.vld); // R2
    AST_VLD_CARRIED: assert property (@(posedge clk) disable iff (!rst_n)
        s3.vld |=> res_vld); // R10
    AST_BUBBLE_CARRIED: assert property (@(posedge clk) disable iff (!rst_n)
        !s3.vld |=> !res_vld); // R2
endmodule

// File: tb/tb_fp_add_pipe.sv
module tb_fp_add_pipe;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        opd_vld = 1'b0;
    logic [24:0] opd_a = '0, opd_b = '0;
    logic        op_sub = 1'b0;
    logic        res_vld;
    logic [24:0] res;

    int n_chk = 0, n_bad = 0;
    logic        q_v [4];
    logic [24:0] q_r [4];
    string       q_t [4];

    fp_add_pipe dut (.clk(clk), .rst_n(rst_n), .opd_vld(opd_vld), .opd_a(opd_a),
                     .opd_b(opd_b), .op_sub(op_sub), .res_vld(res_vld), .res(res));

    always #2 clk = ~clk;

    // Expected result from the requirements (R1, R3-R9)
    function automatic logic [24:0] model(input logic [24:0] a, input logic [24:0] b, input logic s);
        int ea = a[23:16], eb = b[23:16], ma = a[15:0], mb = b[15:0];
        logic sa = a[24], sb = b[24] ^ s;
        int ebig, mbig, msml, d, sum;
        logic gs, ls, rs;
        if (ea >= eb) begin ebig = ea; mbig = ma; gs = sa; msml = mb; ls = sb; d = ea - eb; end
        else          begin ebig = eb; mbig = mb; gs = sb; msml = ma; ls = sa; d = eb - ea; end
        msml = (d >= 16) ? 0 : (msml >> d);
        if (gs == ls)          begin sum = mbig + msml; rs = gs; end
        else if (mbig >= msml) begin sum = mbig - msml; rs = gs; end
        else                   begin sum = msml - mbig; rs = ls; end
        if (sum == 0) return 25'd0;
        if (sum >= 65536) begin sum = sum >> 1; ebig++; end
        while (sum < 32768) begin sum = sum << 1; ebig--; end
        return {rs, 8'(ebig), 16'(sum)};
    endfunction

    task automatic check_out();
        n_chk++;
        if (res_vld !== q_v[3] || (q_v[3] && res !== q_r[3])) begin
            n_bad++;
            $display("FAIL %s: vld=%b res=%h expected vld=%b res=%h",
                     q_t[3], res_vld, res, q_v[3], q_r[3]);
        end
    endtask

    // One clock of stimulus; compares the output due from four clocks earlier
    task automatic drive(input logic v, input logic [24:0] a, input logic [24:0] b,
                         input logic s, input string tag);
        @(negedge clk);
        check_out();
        for (int i = 3; i > 0; i--) begin
            q_v[i] = q_v[i-1]; q_r[i] = q_r[i-1]; q_t[i] = q_t[i-1];
        end
        q_v[0] = v; q_r[0] = model(a, b, s); q_t[0] = tag;
        opd_vld = v; opd_a = a; opd_b = b; op_sub = s;
    endtask

    function automatic logic [24:0] rnd_opd();
        if ($urandom_range(0, 19) == 0) return 25'd0;
        return {1'($urandom), 8'($urandom_range(20, 230)), 1'b1, 15'($urandom)};
    endfunction

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [24:0] ra, rb;
        void'($urandom(32'd4711));
        for (int i = 0; i < 4; i++) begin q_v[i] = 1'b0; q_r[i] = '0; q_t[i] = "R2"; end
        repeat (3) @(negedge clk);
        // R2 reset state
        n_chk++;
        if (res_vld !== 1'b0 || res !== '0) begin
            n_bad++; $display("FAIL R2 reset: vld=%b res=%h expected 0/0", res_vld, res);
        end
        rst_n = 1'b1;
        // R6: 1.0 + 1.0 carries out
        drive(1, {1'b0, 8'd127, 16'h8000}, {1'b0, 8'd127, 16'h8000}, 0, "R6 carry");
        // R9: x - x is the all-zero word
        drive(1, {1'b1, 8'd140, 16'hA5A5}, {1'b1, 8'd140, 16'hA5A5}, 1, "R9 zero");
        // R8/R7: 1.0 - 1.5 gives negative 0.5
        drive(1, {1'b0, 8'd127, 16'h8000}, {1'b0, 8'd127, 16'hC000}, 1, "R8 sign flip");
        // R4: difference of 30 flushes the smaller operand
        drive(1, {1'b0, 8'd150, 16'h9234}, {1'b0, 8'd120, 16'hFFFF}, 0, "R4 flush");
        // R4: difference exactly 16
        drive(1, {1'b1, 8'd100, 16'h8001}, {1'b0, 8'd116, 16'hC000}, 0, "R4 edge16");
        // R3: difference 15 keeps one bit
        drive(1, {1'b0, 8'd115, 16'h8000}, {1'b0, 8'd100, 16'hFFFF}, 0, "R3 shift15");
        // R5: a - (negative b) adds magnitudes
        drive(1, {1'b0, 8'd130, 16'h8000}, {1'b1, 8'd129, 16'h8000}, 1, "R5 sub neg");
        // R7: cancellation leaving many leading zeros
        drive(1, {1'b0, 8'd90, 16'h8001}, {1'b0, 8'd90, 16'h8000}, 1, "R7 deep lz");
        // R2: bubble between operations
        drive(0, '0, '0, 0, "R2 bubble");
        // R1: operand zero plus value
        drive(1, 25'd0, {1'b1, 8'd60, 16'hB000}, 0, "R1 zero opd");
        // R10: back-to-back random stream with occasional bubbles
        for (int k = 0; k < 400; k++) begin
            ra = rnd_opd();
            rb = ($urandom_range(0, 9) == 0) ? ra : rnd_opd();
            drive($urandom_range(0, 7) != 0, ra, rb, 1'($urandom), "R10 stream");
        end
        for (int k = 0; k < 5; k++) drive(0, '0, '0, 0, "R2 drain");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule